// File: doc/BRIEF.md
# Burst Address Sequencer with Linear and Interleaved Order

This block produces the address for each beat of a four-beat burst into a synchronous burst memory. When an access starts, a load strobe captures the full starting address. The two low bits seed a 2-bit offset counter. Each later beat is requested with an advance strobe, and the block then presents the next address of the burst. The upper address bits stay frozen at their loaded value. The low bits walk through a group of four addresses and wrap around inside that group.

A static strap input selects the order of the walk. In linear order the beat number is added to the starting offset, modulo four. In interleaved order the beat number is XORed with the starting offset. An advance-inhibit input suspends counting even while advance is asserted. A load always takes priority over an advance in the same cycle.

The address output is driven directly from registered state. A load or an advance sampled at a rising edge therefore shows on the output right after that edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and after it is released with no load, addr_o is all zeros.
- R2: A load (load_i=1) sampled at a rising edge makes addr_o equal start_addr_i right after that edge, in either order mode.
- R3: With mode_i=0 (linear), after n counted advances since the last load, addr_o[1:0] equals (start[1:0] + n) mod 4.
- R4: With mode_i=1 (interleaved), after n counted advances since the last load, addr_o[1:0] equals start[1:0] XOR (n mod 4).
- R5: mode_i=0 selects linear order and mode_i=1 selects interleaved order. For starting offsets 1 and 3 the two orders give different sequences.
- R6: An advance is counted only at an edge where adv_i=1, adv_hold_i=0 and load_i=0. In every other cycle addr_o keeps its value.
- R7: adv_hold_i=1 blocks counting even while adv_i=1.
- R8: addr_o[ADDR_W-1:2] keeps its loaded value for the whole burst. After the fourth counted beat, the low bits return to the starting offset and the upper bits do not change.
- R9: When load_i=1 and adv_i=1 at the same edge, the load wins and addr_o shows the new starting address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Burst order strap: 0 selects linear, 1 selects interleaved |
| load_i | input | 1 | Starts a burst by capturing start_addr_i |
| start_addr_i | input | ADDR_W | Starting address of the burst |
| adv_i | input | 1 | Requests the next beat |
| adv_hold_i | input | 1 | Suspends advancing while high |
| addr_o | output | ADDR_W | Current beat address |

## Verification
Two situations are hard to reach from the ports. The first is a wrap after the fourth beat that is reached through a mix of counted, held and inhibited cycles. The second is a load that collides with an advance. The bench handles both with a sweep over both modes, all four starting offsets and several upper-bit patterns. During each sweep it drives an irregular advance and inhibit pattern for seven cycles, so each burst passes the group boundary after interruptions. The sweep ends with deliberate load-plus-advance edges, including one placed directly after a counted beat.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned OFS_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  function automatic logic [OFS_W-1:0] beat_offset(
    input order_e             ord,
    input logic [OFS_W-1:0]   base,
    input logic [OFS_W-1:0]   beat
  );
    if (ord == ORD_INTERLEAVE) return base ^ beat;
    return base + beat;
  endfunction
endpackage

// File: rtl/burst_seed_reg.sv
module burst_seed_reg #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OFS_W  = 2,
  localparam int unsigned UP_W  = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [UP_W-1:0]   upper_o,
  output logic [OFS_W-1:0]  base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_o <= '0;
      base_o  <= '0;
    end else if (load_i) begin
      upper_o <= start_addr_i[ADDR_W-1:OFS_W];
      base_o  <= start_addr_i[OFS_W-1:0];
    end
  end

  // R8
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(upper_o));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned OFS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic             adv_hold_i,
  output logic [OFS_W-1:0] beat_o
);
  logic step;
  assign step = adv_i & ~adv_hold_i & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_o <= '0;
    else if (load_i) beat_o <= '0;
    else if (step)   beat_o <= beat_o + 1'b1;
  end

  // R9
  load_clears_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> beat_o == '0);
  // R6
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !adv_hold_i && !load_i) |=> beat_o == $past(beat_o) + 1'b1);
  // R7
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (!adv_i || adv_hold_i)) |=> $stable(beat_o));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  logic         mode_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] beat_i,
  output logic [W-1:0] ofs_o
);
  order_e ord;
  assign ord   = order_e'(mode_i);
  assign ofs_o = beat_offset(ord, base_i, beat_i);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned UP_W  = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_i,
  input  logic              adv_hold_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [UP_W-1:0]  upper;
  logic [OFS_W-1:0] base, beat, ofs;

  burst_seed_reg #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_seed (
    .clk_i, .rst_ni, .load_i, .start_addr_i,
    .upper_o(upper), .base_o(base)
  );

  burst_beat_ctr #(.OFS_W(OFS_W)) u_beat (
    .clk_i, .rst_ni, .load_i, .adv_i, .adv_hold_i, .beat_o(beat)
  );

  burst_order_map #(.W(OFS_W)) u_map (
    .mode_i, .base_i(base), .beat_i(beat), .ofs_o(ofs)
  );

  assign addr_o = {upper, ofs};

  // R2
  load_shows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(start_addr_i));
  // R6
  idle_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i && $stable(mode_i)) |=> $stable(addr_o));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0, load = 1'b0, adv = 1'b0, hold = 1'b0;
  logic [AW-1:0] start = '0;
  logic [AW-1:0] addr;

  int checks = 0, errors = 0;
  logic [AW-1:0] exp_start = '0;
  int            exp_n = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .load_i(load),
    .start_addr_i(start), .adv_i(adv), .adv_hold_i(hold), .addr_o(addr)
  );

  function automatic logic [AW-1:0] model(input logic m, input logic [AW-1:0] s, input int n);
    logic [1:0] lo;
    lo = m ? (s[1:0] ^ 2'(n % 4)) : 2'((s[1:0] + n) % 4);
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (addr !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%0h expected %0h", req, addr, exp);
    end
  endtask

  // drive after one edge, evaluate 2 ns after the next
  task automatic cyc(input logic l, input logic [AW-1:0] s, input logic a, input logic h);
    load = l; start = s; adv = a; hold = h;
    @(posedge clk); #2;
    if (l) begin exp_start = s; exp_n = 0; end
    else if (a && !h) exp_n++;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3; check("R1 in reset", '0);
    @(posedge clk); #2; check("R1 in reset", '0);
    rst_n = 1'b1;
    cyc(0, 8'h5a, 0, 0); check("R1 after release", '0);
    cyc(0, 8'h5a, 1, 1); check("R1/R7 inhibited after release", '0);

    for (int m = 0; m < 2; m++) begin
      mode = 1'(m);
      for (int u = 0; u < 3; u++) begin
        for (int s = 0; s < 4; s++) begin
          logic [AW-1:0] st;
          st = {6'(8'h15 * (u + 1) + s * 3 + m * 7), 2'(s)};
          cyc(1, st, (s % 2 == 1), 0);
          check("R2 load", st);
          check((s % 2 == 1) ? "R9 load over advance" : "R2 load", model(mode, exp_start, 0));
          for (int k = 0; k < 7; k++) begin
            logic a, h;
            logic [AW-1:0] prev;
            prev = addr;
            a = (k % 3 != 2);
            h = ((k + u) % 4 == 3);
            cyc(0, ~st, a, h);
            if (a && !h) check(m ? "R4/R5 interleaved" : "R3/R5 linear", model(mode, exp_start, exp_n));
            else if (a) check("R7 inhibit", prev);
            else check("R6 hold", prev);
            checks++;
            if (addr[AW-1:2] !== st[AW-1:2]) begin
              errors++;
              $display("FAIL R8 upper: %0h expected %0h", addr[AW-1:2], st[AW-1:2]);
            end
          end
          // R8 wrap: exp_n >= 4 here, so the offset has gone past the group boundary
          if (exp_n >= 4) check("R8 wrap", model(mode, exp_start, exp_n));
        end
      end
    end

    // R5: start offset 1 gives different second beats in the two orders
    mode = 1'b0; cyc(1, 8'h41, 0, 0); cyc(0, 0, 1, 0); check("R5 linear 1->2", 8'h42);
    cyc(0, 0, 1, 0); check("R3 linear 2->3", 8'h43);
    mode = 1'b1; cyc(1, 8'h41, 0, 0); cyc(0, 0, 1, 0); check("R5 interleaved 1->0", 8'h40);
    cyc(0, 0, 1, 0); check("R4 interleaved 0->3", 8'h43);
    cyc(0, 0, 1, 0); check("R4 interleaved 3->2", 8'h42);
    cyc(0, 0, 1, 0); check("R8 interleaved wrap to 1", 8'h41);
    // R9 load collides with an advance right after a counted beat
    cyc(0, 0, 1, 0); check("R4 beat", 8'h40);
    cyc(1, 8'hc6, 1, 0); check("R9 collision", 8'hc6);
    cyc(0, 0, 1, 0); check("R4 after collision", 8'hc7);
    mode = 1'b0; cyc(1, 8'hc6, 1, 1); check("R9 collision with hold", 8'hc6);
    cyc(0, 0, 1, 0); check("R3 after collision", 8'hc7);
    cyc(0, 0, 1, 0); check("R8 linear wrap", 8'hc4);
    cyc(0, 0, 1, 0); check("R3 linear", 8'hc5);
    cyc(0, 0, 1, 0); check("R8 back to start", 8'hc6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule